// File: doc/BRIEF.md
# DDR Mode Register Command Decoder

This block sits behind a memory command path and interprets mode-register write commands. Each command arrives as a single-cycle strobe with a 14-bit address word. The low seven bits carry the programmed fields: burst length, burst ordering and read latency. The high seven bits select the operating action. That action is either a plain mode update, a mode update that also restarts the clock-alignment loop, or a reserved pattern that must not be acted on.

Accepted fields are held in a register and driven out continuously. A restart request produces a one-cycle pulse toward the alignment-loop logic. It also raises a pending status, which stays high until a plain mode update arrives. Commands that break that ordering, use a reserved action pattern or carry an unsupported field code raise single-cycle error pulses. A rejected command leaves the stored mode untouched. Support for the two optional read latencies is chosen by parameters.

All outputs are registered. The effect of a command sampled at a rising edge is visible right after that edge.

Top module: `mode_reg_decoder`

## Requirements
- R1: After synchronous reset, burst length code is 001, burst ordering is 0, latency code is 110, pending is 0 and every pulse output is 0.
- R2: A command whose bits 13..7 are all zero and whose fields are valid stores bits 2..0 as the burst length code and bits 6..4 as the latency code, visible one cycle after the strobe.
- R3: Bit 3 of an accepted command is stored as burst ordering, where 0 means sequential and 1 means interleaved.
- R4: A command with bit 8 set, bits 7 and 13..9 clear and valid fields stores its fields, pulses dll_reset_pulse for one cycle and sets dll_pending.
- R5: dll_pending stays high until an accepted plain mode update (bits 13..7 zero, valid fields), which clears it.
- R6: While dll_pending is high, any command that is not an accepted plain mode update pulses err_sequence.
- R7: A command with any other pattern on bits 13..7 pulses err_reserved_mode, leaves the stored fields and dll_pending unchanged and produces no dll_reset_pulse.
- R8: Burst length codes 001 (2), 010 (4) and 011 (8) are valid. Any other code pulses err_bad_field, and the command is then not applied.
- R9: Latency codes 010 (2) and 110 (2.5) are always valid. Code 101 (1.5) is valid only when EN_LAT_1P5 is set, and code 011 (3) only when EN_LAT_3 is set. Any other code pulses err_bad_field, and the command is then not applied.
- R10: In a cycle with no strobe, the stored fields and dll_pending hold and every pulse output is low in the next cycle.
- R11: err_reserved_mode, err_bad_field and dll_reset_pulse are mutually exclusive and last exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Mode-register write strobe |
| cmd_addr | input | 14 | Command address word |
| burst_len_code | output | 3 | Stored burst length code |
| burst_interleaved | output | 1 | Stored burst ordering, 1 = interleaved |
| latency_code | output | 3 | Stored read latency code |
| dll_reset_pulse | output | 1 | One-cycle restart pulse for the alignment loop |
| dll_pending | output | 1 | Restart issued, plain mode update still owed |
| err_reserved_mode | output | 1 | Pulse: reserved action pattern seen |
| err_bad_field | output | 1 | Pulse: unsupported burst length or latency code |
| err_sequence | output | 1 | Pulse: ordering rule after a restart broken |

## Verification
The checker assumes that cmd_valid and cmd_addr are free of unknown values and are steady around each rising edge. It also assumes that a strobe lasts exactly one sampled edge for each intended command. The bench drives both inputs only on falling edges and holds the strobe for one cycle per command. It leaves at least one idle cycle between commands, so each pulse can be seen rising and falling. The bench instance enables the 1.5 latency and disables latency 3, so both the accepted and the rejected branch of the optional codes are exercised.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int FIELD_W = 7;

    typedef enum logic [1:0] {
        OP_NORMAL    = 2'd0,
        OP_DLL_RESET = 2'd1,
        OP_RESERVED  = 2'd2
    } op_class_e;

    typedef struct packed {
        logic [2:0] lat;
        logic       itlv;
        logic [2:0] blen;
    } mode_fields_t;

    localparam logic [2:0] BL_2    = 3'b001;
    localparam logic [2:0] BL_4    = 3'b010;
    localparam logic [2:0] BL_8    = 3'b011;
    localparam logic [2:0] LAT_2   = 3'b010;
    localparam logic [2:0] LAT_2P5 = 3'b110;
    localparam logic [2:0] LAT_1P5 = 3'b101;
    localparam logic [2:0] LAT_3   = 3'b011;

    localparam mode_fields_t FIELDS_AT_RESET = '{lat: LAT_2P5, itlv: 1'b0, blen: BL_2};

    function automatic logic blen_valid(input logic [2:0] code);
        return (code == BL_2) || (code == BL_4) || (code == BL_8);
    endfunction

    function automatic logic lat_valid(input logic [2:0] code,
                                       input logic       allow_1p5,
                                       input logic       allow_3);
        return (code == LAT_2) || (code == LAT_2P5) ||
               (allow_1p5 && code == LAT_1P5) ||
               (allow_3 && code == LAT_3);
    endfunction

endpackage

// File: rtl/mrd_classify.sv
module mrd_classify
    import mrd_pkg::*;
#(
    parameter int   ADDR_W     = 14,
    parameter int   DLL_BIT    = 8,
    parameter logic EN_LAT_1P5 = 1'b0,
    parameter logic EN_LAT_3   = 1'b0
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    output op_class_e         op_class,
    output mode_fields_t      fields,
    output logic              fields_ok
);
    localparam int OPF_W = ADDR_W - FIELD_W;
    localparam logic [OPF_W-1:0] OPF_DLL = OPF_W'(1) << (DLL_BIT - FIELD_W);

    logic [OPF_W-1:0] opf;

    assign opf    = cmd_addr[ADDR_W-1:FIELD_W];
    assign fields = mode_fields_t'(cmd_addr[FIELD_W-1:0]);

    always_comb begin
        if (opf == '0)
            op_class = OP_NORMAL;
        else if (opf == OPF_DLL)
            op_class = OP_DLL_RESET;
        else
            op_class = OP_RESERVED;
    end

    assign fields_ok = blen_valid(fields.blen) &&
                       lat_valid(fields.lat, EN_LAT_1P5, EN_LAT_3);

endmodule

// File: rtl/mrd_mode_store.sv
module mrd_mode_store
    import mrd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  mode_fields_t fields_in,
    output mode_fields_t fields_q
);
    always_ff @(posedge clk) begin
        if (rst)
            fields_q <= FIELDS_AT_RESET;
        else if (load)
            fields_q <= fields_in;
    end
endmodule

// File: rtl/mrd_seq_track.sv
module mrd_seq_track
    import mrd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  op_class_e op_class,
    input  logic      fields_ok,
    output logic      load,
    output logic      dll_pulse,
    output logic      pending,
    output logic      err_mode,
    output logic      err_field,
    output logic      err_seq
);
    logic accept_normal, accept_dll, is_reserved, is_badfield;

    assign is_reserved   = cmd_valid && (op_class == OP_RESERVED);
    assign is_badfield   = cmd_valid && !is_reserved && !fields_ok;
    assign accept_normal = cmd_valid && (op_class == OP_NORMAL) && fields_ok;
    assign accept_dll    = cmd_valid && (op_class == OP_DLL_RESET) && fields_ok;
    assign load          = accept_normal || accept_dll;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            dll_pulse <= 1'b0;
            err_mode  <= 1'b0;
            err_field <= 1'b0;
            err_seq   <= 1'b0;
        end else begin
            dll_pulse <= accept_dll;
            err_mode  <= is_reserved;
            err_field <= is_badfield;
            err_seq   <= pending && cmd_valid && !accept_normal;
            if (accept_dll)
                pending <= 1'b1;
            else if (accept_normal)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/mode_reg_decoder.sv
module mode_reg_decoder
    import mrd_pkg::*;
#(
    parameter int   ADDR_W     = 14,
    parameter logic EN_LAT_1P5 = 1'b0,
    parameter logic EN_LAT_3   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [2:0]        burst_len_code,
    output logic              burst_interleaved,
    output logic [2:0]        latency_code,
    output logic              dll_reset_pulse,
    output logic              dll_pending,
    output logic              err_reserved_mode,
    output logic              err_bad_field,
    output logic              err_sequence
);
    op_class_e    op_class;
    mode_fields_t cmd_fields;
    mode_fields_t stored;
    logic         fields_ok;
    logic         load;

    mrd_classify #(
        .ADDR_W    (ADDR_W),
        .DLL_BIT   (8),
        .EN_LAT_1P5(EN_LAT_1P5),
        .EN_LAT_3  (EN_LAT_3)
    ) u_classify (
        .cmd_addr (cmd_addr),
        .op_class (op_class),
        .fields   (cmd_fields),
        .fields_ok(fields_ok)
    );

    mrd_seq_track u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .op_class (op_class),
        .fields_ok(fields_ok),
        .load     (load),
        .dll_pulse(dll_reset_pulse),
        .pending  (dll_pending),
        .err_mode (err_reserved_mode),
        .err_field(err_bad_field),
        .err_seq  (err_sequence)
    );

    mrd_mode_store u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .fields_in(cmd_fields),
        .fields_q (stored)
    );

    assign burst_len_code    = stored.blen;
    assign burst_interleaved = stored.itlv;
    assign latency_code      = stored.lat;

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [13:0] cmd_addr,
    input logic [2:0]  burst_len_code,
    input logic        burst_interleaved,
    input logic [2:0]  latency_code,
    input logic        dll_reset_pulse,
    input logic        dll_pending,
    input logic        err_reserved_mode,
    input logic        err_bad_field,
    input logic        err_sequence
);
    logic [6:0] stored;
    logic       opf_reserved;
    assign stored       = {latency_code, burst_interleaved, burst_len_code};
    assign opf_reserved = (cmd_addr[13:7] != 7'd0) && (cmd_addr[13:7] != 7'b0000010);

    // R10: idle cycles change nothing
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(stored) && $stable(dll_pending) &&
                       !dll_reset_pulse && !err_reserved_mode && !err_bad_field && !err_sequence);

    // R7: reserved action pattern is flagged and ignored
    a_r7_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && opf_reserved |=> err_reserved_mode && $stable(stored) &&
                                      $stable(dll_pending) && !dll_reset_pulse);

    // R4: a restart pulse always comes with pending set
    a_r4_pulse_sets_pending: assert property (@(posedge clk) disable iff (rst)
        dll_reset_pulse |-> dll_pending);

    // R5: pending only drops after a plain mode update
    a_r5_clear_on_normal: assert property (@(posedge clk) disable iff (rst)
        $fell(dll_pending) |-> $past(cmd_valid) && ($past(cmd_addr[13:7]) == 7'd0));

    // R11: pulse outputs are mutually exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dll_reset_pulse, err_reserved_mode, err_bad_field}));

    // R6: a sequence error only appears while a restart is owed
    a_r6_seq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        err_sequence |-> $past(dll_pending));

endmodule

bind mode_reg_decoder mrd_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_valid        (cmd_valid),
    .cmd_addr         (cmd_addr),
    .burst_len_code   (burst_len_code),
    .burst_interleaved(burst_interleaved),
    .latency_code     (latency_code),
    .dll_reset_pulse  (dll_reset_pulse),
    .dll_pending      (dll_pending),
    .err_reserved_mode(err_reserved_mode),
    .err_bad_field    (err_bad_field),
    .err_sequence     (err_sequence)
);

// File: tb/mode_reg_decoder_tb.sv
module mode_reg_decoder_tb;
    localparam int   CLK_PERIOD = 10;
    localparam logic EN15       = 1'b1;
    localparam logic EN3        = 1'b0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [13:0] cmd_addr = '0;
    logic [2:0]  burst_len_code, latency_code;
    logic        burst_interleaved, dll_reset_pulse, dll_pending;
    logic        err_reserved_mode, err_bad_field, err_sequence;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    logic [2:0] e_bl = 3'b001;
    logic       e_bt = 1'b0;
    logic [2:0] e_lat = 3'b110;
    logic       e_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_reg_decoder #(.ADDR_W(14), .EN_LAT_1P5(EN15), .EN_LAT_3(EN3)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .burst_len_code(burst_len_code), .burst_interleaved(burst_interleaved),
        .latency_code(latency_code), .dll_reset_pulse(dll_reset_pulse),
        .dll_pending(dll_pending), .err_reserved_mode(err_reserved_mode),
        .err_bad_field(err_bad_field), .err_sequence(err_sequence)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] mk(input logic [6:0] opf, input logic [2:0] lat,
                                       input logic bt, input logic [2:0] bl);
        return {opf, lat, bt, bl};
    endfunction

    task automatic check_state(input string req);
        check(req, "burst_len_code", burst_len_code, e_bl);
        check(req, "burst_interleaved", burst_interleaved, e_bt);
        check(req, "latency_code", latency_code, e_lat);
        check(req, "dll_pending", dll_pending, e_pend);
    endtask

    task automatic check_quiet(input string req);
        check(req, "dll_reset_pulse", dll_reset_pulse, 0);
        check(req, "err_reserved_mode", err_reserved_mode, 0);
        check(req, "err_bad_field", err_bad_field, 0);
        check(req, "err_sequence", err_sequence, 0);
    endtask

    // Issue one command, predict its effect from the requirements, check it,
    // then check that every pulse has dropped one cycle later (R11).
    task automatic issue(input string req, input logic [13:0] a);
        logic [6:0] opf;
        logic bl_ok, lat_ok, ok, is_norm, is_dll, is_res;
        logic x_dll, x_res, x_fld, x_seq;
        opf     = a[13:7];
        is_norm = (opf == 7'd0);
        is_dll  = (opf == 7'b0000010);
        is_res  = !is_norm && !is_dll;
        bl_ok   = (a[2:0] == 3'b001) || (a[2:0] == 3'b010) || (a[2:0] == 3'b011);
        lat_ok  = (a[6:4] == 3'b010) || (a[6:4] == 3'b110) ||
                  (EN15 && a[6:4] == 3'b101) || (EN3 && a[6:4] == 3'b011);
        ok      = bl_ok && lat_ok;
        x_res   = is_res;
        x_fld   = !is_res && !ok;
        x_dll   = is_dll && ok;
        x_seq   = e_pend && !(is_norm && ok);
        if (!is_res && ok) begin
            e_bl  = a[2:0];
            e_bt  = a[3];
            e_lat = a[6:4];
            e_pend = is_dll;
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr  = '0;
        check_state(req);
        check(req, "dll_reset_pulse", dll_reset_pulse, x_dll);
        check(req, "err_reserved_mode", err_reserved_mode, x_res);
        check(req, "err_bad_field", err_bad_field, x_fld);
        check(req, "err_sequence", err_sequence, x_seq);
        @(negedge clk);
        check_quiet("R11");
        check_state("R10");
    endtask

    task automatic t_reset();
        check_state("R1");
        check_quiet("R1");
    endtask

    task automatic t_normal();
        issue("R2", mk(7'd0, 3'b010, 1'b0, 3'b011));
        issue("R3", mk(7'd0, 3'b110, 1'b1, 3'b010));
        issue("R3", mk(7'd0, 3'b010, 1'b0, 3'b001));
    endtask

    task automatic t_idle();
        repeat (4) @(negedge clk);
        check_state("R10");
        check_quiet("R10");
    endtask

    task automatic t_dll();
        issue("R4", mk(7'b0000010, 3'b010, 1'b1, 3'b010));
        repeat (3) @(negedge clk);
        check_state("R5");
        issue("R6", mk(7'b0000001, 3'b110, 1'b0, 3'b011));
        issue("R6", mk(7'd0, 3'b000, 1'b0, 3'b011));
        issue("R6", mk(7'b0000010, 3'b110, 1'b0, 3'b001));
        issue("R5", mk(7'd0, 3'b110, 1'b0, 3'b011));
        check("R5", "dll_pending cleared", dll_pending, 0);
    endtask

    task automatic t_bad_bl();
        issue("R8", mk(7'd0, 3'b010, 1'b1, 3'b000));
        issue("R8", mk(7'd0, 3'b010, 1'b1, 3'b100));
        issue("R8", mk(7'b0000010, 3'b010, 1'b1, 3'b111));
        check("R8", "no restart pending", dll_pending, 0);
    endtask

    task automatic t_bad_lat();
        issue("R9", mk(7'd0, 3'b000, 1'b0, 3'b010));
        issue("R9", mk(7'd0, 3'b011, 1'b0, 3'b010));
        issue("R9", mk(7'd0, 3'b101, 1'b1, 3'b010));
        check("R9", "latency 1.5 stored", latency_code, 3'b101);
        issue("R9", mk(7'd0, 3'b111, 1'b0, 3'b011));
    endtask

    task automatic t_reserved();
        issue("R7", mk(7'b0000001, 3'b010, 1'b1, 3'b011));
        issue("R7", mk(7'b1000000, 3'b110, 1'b0, 3'b010));
        issue("R7", mk(7'b0000011, 3'b110, 1'b0, 3'b010));
        issue("R7", mk(7'b0000110, 3'b010, 1'b0, 3'b001));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_idle();
        t_dll();
        t_bad_bl();
        t_bad_lat();
        t_reserved();
        t_idle();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule